// File: doc/BRIEF.md
# Bit-Flipping Hard-Decision LDPC Decoder

This block corrects a received 8-bit hard-decision word against a fixed, regular low-density parity-check code with four parity checks. A strobe loads the word. The block then iterates, one iteration per clock. In each iteration every check computes its parity. Each check then tells each of its member bits which value would make that check hold. Each bit counts the votes against its present value and flips when most of them disagree.

Decoding stops as soon as all four checks hold. It also stops when a parameterised iteration budget runs out, and in that case the block gives up. It reports the final word, a one-cycle done pulse, a success flag and the number of iterations it used. The results stay on the outputs until the next accepted start. A start that arrives while a word is being decoded is ignored.

Top module: `ldpc_bf_decoder`

## Requirements
- R1: Port bit i carries code bit i. The checks cover these bits: check 0 = {1,3,4,7}, check 1 = {0,1,2,5}, check 2 = {2,5,6,7}, check 3 = {0,3,4,6}. A check holds when the XOR of its members is 0.
- R2: The message a check sends to each member bit is the XOR of its other three members.
- R3: Before the first iteration, the working word equals the received word. In each iteration a bit takes three votes: its received bit and the messages from its two checks. The bit flips when at least two of the three votes differ from its present value.
- R4: When all checks hold, decoding ends with ok_o=1, and iters_o gives the number of flip iterations that were done. A word that already satisfies every check finishes with iters_o=0.
- R5: One iteration takes one clock. done_o rises iters_o+1 cycles after the clock edge that accepts the start.
- R6: If the checks still fail after MAX_ITER iterations, done_o is raised with ok_o=0 and iters_o=MAX_ITER, and dec_word_o shows the word left by the last iteration.
- R7: A start_i that arrives while decoding is in progress is ignored. It produces no extra done_o and does not change the result.
- R8: done_o is high for exactly one cycle. dec_word_o, ok_o and iters_o hold their values until the next accepted start.
- R9: After reset, done_o=0, ok_o=0, iters_o=0 and dec_word_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load rx_word_i and begin decoding (only when idle) |
| rx_word_i | input | 8 | Received hard-decision word, bit i = code bit i |
| dec_word_o | output | 8 | Decoded word |
| done_o | output | 1 | One-cycle pulse when a decode finishes |
| ok_o | output | 1 | 1 = all checks hold, 0 = iteration budget exhausted |
| iters_o | output | $clog2(MAX_ITER+1) | Iterations used by the last decode |

## Verification
Some properties are checked by assertions on every cycle. done_o always falls after one cycle. A successful finish always leaves a word whose syndrome is zero. A failed finish always reports the full budget. A start during decoding never resets the iteration counter.

Other behaviours can only be shown by the bench scenarios. These are the exact corrected words, the iteration counts and latencies for clean, single-error, oscillating and pseudo-random inputs, and the absence of a stray result after an ignored start. The bench gets these from its own model of the check and vote rules.

// File: rtl/ldpc_bf_pkg.sv
package ldpc_bf_pkg;
  localparam int N_BITS = 8;
  localparam int N_CHK  = 4;

  typedef logic [N_BITS-1:0] cword_t;

  // Membership mask of check j; bit i set when code bit i takes part.
  function automatic cword_t chk_mask(input int j);
    case (j)
      0:       chk_mask = 8'h9A;  // bits 1,3,4,7
      1:       chk_mask = 8'h27;  // bits 0,1,2,5
      2:       chk_mask = 8'hE4;  // bits 2,5,6,7
      default: chk_mask = 8'h59;  // bits 0,3,4,6
    endcase
  endfunction

  // Number of checks a bit belongs to.
  function automatic int col_weight(input int i);
    int n;
    n = 0;
    for (int j = 0; j < N_CHK; j++) n += int'(chk_mask(j)[i]);
    return n;
  endfunction

  // Parity of the masked word.
  function automatic logic masked_parity(input cword_t w, input cword_t m);
    return ^(w & m);
  endfunction

  // Majority decision: flip when more than half of the votes disagree.
  function automatic logic flip_vote(input int n_disagree, input int n_votes);
    return (2 * n_disagree) > n_votes;
  endfunction
endpackage

// File: rtl/bf_check_array.sv
module bf_check_array
  import ldpc_bf_pkg::*;
(
  input  cword_t                         word_i,
  output logic [N_CHK-1:0]               syn_o,
  output logic [N_CHK-1:0][N_BITS-1:0]   msg_o
);
  for (genvar j = 0; j < N_CHK; j++) begin : g_chk
    localparam cword_t MASK = chk_mask(j);
    assign syn_o[j] = masked_parity(word_i, MASK);
    for (genvar i = 0; i < N_BITS; i++) begin : g_edge
      if (MASK[i]) begin : g_conn
        localparam cword_t OTHERS = MASK & ~(cword_t'(1) << i);
        // value bit i would need so that check j holds
        assign msg_o[j][i] = masked_parity(word_i, OTHERS);
      end else begin : g_none
        assign msg_o[j][i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bf_bit_array.sv
module bf_bit_array
  import ldpc_bf_pkg::*;
(
  input  cword_t                         cur_i,
  input  cword_t                         rx_i,
  input  logic [N_CHK-1:0][N_BITS-1:0]   msg_i,
  output cword_t                         flip_o,
  output cword_t                         next_o
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    localparam int VOTES = col_weight(i) + 1;
    int n_dis;
    always_comb begin
      n_dis = (rx_i[i] != cur_i[i]) ? 1 : 0;
      for (int j = 0; j < N_CHK; j++)
        if (chk_mask(j)[i] && (msg_i[j][i] != cur_i[i])) n_dis++;
      flip_o[i] = flip_vote(n_dis, VOTES);
    end
    assign next_o[i] = cur_i[i] ^ flip_o[i];
  end
endmodule

// File: rtl/bf_ctrl.sv
module bf_ctrl #(
  parameter int MAX_ITER = 8,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          syn_zero_i,
  output logic          load_o,
  output logic          step_o,
  output logic          done_o,
  output logic          ok_o,
  output logic [IW-1:0] iters_o
);
  logic          busy;
  logic [IW-1:0] iter;
  logic          at_limit;
  logic          finish;

  assign at_limit = (iter == IW'(MAX_ITER));
  assign finish   = busy && (syn_zero_i || at_limit);
  assign load_o   = start_i && !busy;
  assign step_o   = busy && !finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      iter    <= '0;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
      iters_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy <= 1'b1;
        iter <= '0;
      end else if (finish) begin
        busy    <= 1'b0;
        done_o  <= 1'b1;
        ok_o    <= syn_zero_i;
        iters_o <= iter;
      end else if (busy) begin
        iter <= iter + 1'b1;
      end
    end
  end

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter <= IW'(MAX_ITER)));  // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !finish) |=> (busy && iter == $past(iter) + 1'b1));  // R7
  AST_FAIL_FULL_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |-> (iters_o == IW'(MAX_ITER)));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R8
endmodule

// File: rtl/ldpc_bf_decoder.sv
module ldpc_bf_decoder #(
  parameter int MAX_ITER = 8,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    rx_word_i,
  output logic [7:0]    dec_word_o,
  output logic          done_o,
  output logic          ok_o,
  output logic [IW-1:0] iters_o
);
  import ldpc_bf_pkg::*;

  cword_t                       rx_q;
  cword_t                       cur_q;
  cword_t                       next_w;
  cword_t                       flips;
  logic [N_CHK-1:0]             syn;
  logic [N_CHK-1:0][N_BITS-1:0] msg;
  logic                         syn_zero;
  logic                         load;
  logic                         step;

  assign syn_zero = (syn == '0);

  bf_check_array u_chk (
    .word_i (cur_q),
    .syn_o  (syn),
    .msg_o  (msg)
  );

  bf_bit_array u_bits (
    .cur_i  (cur_q),
    .rx_i   (rx_q),
    .msg_i  (msg),
    .flip_o (flips),
    .next_o (next_w)
  );

  bf_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .syn_zero_i (syn_zero),
    .load_o     (load),
    .step_o     (step),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .iters_o    (iters_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      cur_q <= '0;
    end else if (load) begin
      rx_q  <= rx_word_i;
      cur_q <= rx_word_i;
    end else if (step) begin
      cur_q <= next_w;
    end
  end

  assign dec_word_o = cur_q;

  AST_OK_CLEAN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ok_o) |-> syn_zero);  // R4
  AST_LOAD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(rx_word_i)));  // R3
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur_q));  // R8
endmodule

// File: tb/sim_ldpc_bf_decoder.sv
module sim_ldpc_bf_decoder;
  localparam int MAX_ITER = 8;
  localparam int IW = $clog2(MAX_ITER + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    rx_word_i = '0;
  logic [7:0]    dec_word_o;
  logic          done_o;
  logic          ok_o;
  logic [IW-1:0] iters_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic prev_done = 1'b0;
  logic [7:0] last_w = '0;
  logic last_ok = 1'b0;
  int last_it = 0;

  typedef struct {
    logic [7:0] w;
    logic       ok;
    int         it;
    int         t0;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  ldpc_bf_decoder #(.MAX_ITER(MAX_ITER)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_word_i(rx_word_i),
    .dec_word_o(dec_word_o), .done_o(done_o), .ok_o(ok_o), .iters_o(iters_o)
  );

  task automatic check(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Independent model: member lists per check (R1), messages as the parity of
  // the other members (R2), 2-of-3 majority with the received bit (R3).
  function automatic void ref_run(input logic [7:0] rx, output logic [7:0] w,
                                  output logic ok, output int it);
    int mem[4][4] = '{'{1,3,4,7}, '{0,1,2,5}, '{2,5,6,7}, '{0,3,4,6}};
    logic [7:0] nw;
    w = rx;
    it = 0;
    ok = 1'b0;
    while (1) begin
      int bad = 0;
      for (int j = 0; j < 4; j++) begin
        int s = 0;
        for (int k = 0; k < 4; k++) s += int'(w[mem[j][k]]);
        if (s % 2 != 0) bad++;
      end
      if (bad == 0) begin ok = 1'b1; break; end
      if (it == MAX_ITER) break;
      nw = w;
      for (int b = 0; b < 8; b++) begin
        int votes = (w[b] != rx[b]) ? 1 : 0;
        for (int j = 0; j < 4; j++) begin
          int others = 0;
          bit member = 0;
          for (int k = 0; k < 4; k++)
            if (mem[j][k] == b) member = 1;
            else others += int'(w[mem[j][k]]);
          if (member && ((others % 2) != int'(w[b]))) votes++;
        end
        if (votes >= 2) nw[b] = ~w[b];
      end
      w = nw;
      it++;
    end
  endfunction

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] rx);
    exp_t e;
    wait_idle();
    // R8: previous results still held before the next start
    check(dec_word_o == last_w, "R8 word held", dec_word_o, last_w);
    check(ok_o == last_ok && int'(iters_o) == last_it, "R8 flags held", iters_o, last_it);
    ref_run(rx, e.w, e.ok, e.it);
    e.t0 = cyc + 1;
    exp_q.push_back(e);
    start_i = 1'b1;
    rx_word_i = rx;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done_o) check(0, "R8 done longer than one cycle", 1, 0);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(dec_word_o == e.w, e.ok ? "R4 word" : "R6 word", dec_word_o, e.w);
          check(ok_o == e.ok, e.ok ? "R4 ok" : "R6 ok", ok_o, e.ok);
          check(int'(iters_o) == e.it, "R5 iters", iters_o, e.it);
          check(cyc - e.t0 == e.it + 1, "R5 latency", cyc - e.t0, e.it + 1);
          last_w = e.w; last_ok = e.ok; last_it = e.it;
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(done_o == 0 && ok_o == 0, "R9 flags", {done_o, ok_o}, 0);
    check(iters_o == 0, "R9 iters", iters_o, 0);
    check(dec_word_o == 0, "R9 word", dec_word_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h00);                    // R4 clean, zero iterations
    send(8'hFF);                    // R1 all ones satisfies every check
    for (int b = 0; b < 8; b++) send(8'h00 ^ (8'h01 << b));   // R3 single errors
    for (int b = 0; b < 8; b++) send(8'hFF ^ (8'h01 << b));
    send(8'h03);                    // R6 oscillating pattern, budget exhausted
    for (int n = 0; n < 24; n++) begin
      send(lfsr);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // R7: start during a long decode is ignored
    send(8'h03);
    repeat (3) @(negedge clk);
    start_i = 1'b1; rx_word_i = 8'hF0;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (12) @(negedge clk);
    check(dec_word_o == last_w, "R7 result unchanged", dec_word_o, last_w);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule